// File: doc/BRIEF.md
# Receive Output Formatter

This block sits after a clock and data recovery stage. Each cycle of the bit clock it takes in one recovered bit. It can group the bits into 4-bit words and present them with a word-rate output clock. It can also pass the bits straight through on the lowest output lane with a bit-rate or half-bit-rate clock. The same datapath serves both styles. Control inputs choose the style, the bit order within a word and a double-data-rate clock option. They also set the position of the output clock edge relative to the word data, and they can switch the clock and data outputs off.

All state runs on the bit clock and is reset by an asynchronous active-low reset. Word framing begins with the first bit sampled after reset is released. Phase offsets are modelled in whole bit-clock cycles. The two half-UI settings are rounded so that the four settings stay distinct. Disabled outputs are held at zero, and the internal framing keeps running while they are disabled.

Top module: `rxfmt_top`

## Requirements
- R1: In word mode the first word holds the first four bits sampled after reset is released. It appears on `dout` just after the fourth sampling edge. A new word follows every four edges, and `dout` holds its value between loads. `dout` is zero until the first load.
- R2: With `cfg_rev`=0 the earliest bit of a word is on `dout[3]` and the latest is on `dout[0]`.
- R3: With `cfg_rev`=1 the order is mirrored: the earliest bit is on `dout[0]` and the latest is on `dout[3]`.
- R4: With `cfg_serial`=1, `dout[0]` shows the bit sampled at the most recent edge, and `dout[3:1]` are zero.
- R5: In word mode with `cfg_ddr`=0 and phase code 0, `clk_out` has a period of four bit cycles and is high for two of them. After sampling edge k it equals 1 when ((k+1) mod 4) < 2, so its rising edge falls with the word update.
- R6: `cfg_phase` delays the word-mode clock by d bit cycles. Code 0 gives d=0, code 1 (+2 UI) gives d=2, code 2 (+0.5 UI) gives d=1, and code 3 (-1.5 UI) gives d=3, which is -1 modulo 4. After edge k the non-DDR clock is 1 when ((k+1-d) mod 4) < 2.
- R7: With `cfg_ddr`=1 in word mode, `clk_out` starts low after reset and toggles once per word. It toggles just after each edge k where (k+1-d) mod 4 = 0, so the words change on both of its edges.
- R8: In serial mode with `cfg_ser_full`=0, `clk_out` starts low and toggles after every sampling edge. `cfg_phase` has no effect on it.
- R9: In serial mode with `cfg_ser_full`=1, `clk_out` follows the bit clock: it is high while the bit clock is high and low while it is low.
- R10: `cfg_clk_off`=1 forces `clk_out` to 0 at once without disturbing the data outputs. When it is cleared, the clock resumes at the phase R5 to R7 give.
- R11: `cfg_dat_off`=1 forces `dout` to 0 at once. Framing continues while it is set, so after it clears the word on `dout` is the one that R1 to R3 give for that cycle.
- R12: While `rst_n` is low, `dout` and `clk_out` are 0 in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_in | input | 1 | Recovered data bit, sampled on each rising edge |
| cfg_serial | input | 1 | 1 selects serial output, 0 selects 4-bit words |
| cfg_rev | input | 1 | 1 mirrors the bit order within a word |
| cfg_ddr | input | 1 | Word mode: 1 halves the output clock rate |
| cfg_ser_full | input | 1 | Serial mode: 1 gives a bit-rate output clock |
| cfg_phase | input | 2 | Word-mode clock phase code (see R6) |
| cfg_clk_off | input | 1 | 1 forces the output clock to zero |
| cfg_dat_off | input | 1 | 1 forces the data outputs to zero |
| dout | output | 4 | Word or serial data lanes |
| clk_out | output | 1 | Output clock |

## Verification
The assertions check the following on every cycle:
- the forcing to zero by both disable controls,
- the one-edge path from `ser_in` to lane 0 in serial mode,
- the toggling of the half-rate serial clock,
- the four-cycle word-load cadence counted from reset,
- the holding of word data between loads.

The bit ordering of each word, the mapping of phase codes to clock delays, the DDR toggle points and the bit-clock pass-through in full-rate serial mode depend on the stimulus history. Only the bench's scenarios show them. The same is true of framing surviving a data-disable window, which the bench checks against values computed from the input pattern.

// File: rtl/rxfmt_pkg.sv
package rxfmt_pkg;

  // Output clock styles, one per combination of the mode controls.
  typedef enum logic [1:0] {
    CK_PAR_FULL = 2'd0,
    CK_PAR_DDR  = 2'd1,
    CK_SER_HALF = 2'd2,
    CK_SER_FULL = 2'd3
  } clk_mode_e;

  // Phase code to whole-cycle delay of the word clock.
  // Half-UI settings round so the four codes stay distinct.
  function automatic int unsigned phase_delay(input logic [1:0] code,
                                              input int unsigned lanes);
    case (code)
      2'd0:    return 0;
      2'd1:    return lanes / 2;
      2'd2:    return 1;
      default: return lanes - 1;
    endcase
  endfunction

  // Offset of a frame position from the delayed clock origin.
  function automatic int unsigned phase_offset(input int unsigned pos,
                                               input int unsigned dly,
                                               input int unsigned lanes);
    return (pos + lanes - dly) % lanes;
  endfunction

  // Level of the non-DDR word clock at a given frame position.
  function automatic logic par_clk_level(input int unsigned pos,
                                         input int unsigned dly,
                                         input int unsigned lanes);
    return phase_offset(pos, dly, lanes) < (lanes / 2);
  endfunction

  // DDR clock toggles where the delayed origin is reached.
  function automatic logic ddr_toggle(input int unsigned pos,
                                      input int unsigned dly,
                                      input int unsigned lanes);
    return phase_offset(pos, dly, lanes) == 0;
  endfunction

  function automatic clk_mode_e pick_clk_mode(input logic serial,
                                              input logic ddr,
                                              input logic ser_full);
    if (serial) return ser_full ? CK_SER_FULL : CK_SER_HALF;
    return ddr ? CK_PAR_DDR : CK_PAR_FULL;
  endfunction

endpackage

// File: rtl/rxfmt_framer.sv
module rxfmt_framer #(
  parameter int unsigned LANES = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ser_in,
  input  logic                         rev,
  output logic [$clog2(LANES)-1:0]     pos_nx_o,
  output logic                         load_o,
  output logic [LANES-1:0]             word_o,
  output logic                         ser_bit_o
);
  localparam int unsigned CNT_W = $clog2(LANES);

  logic [CNT_W-1:0] pos_q;
  logic [LANES-1:0] shf_q;
  logic [LANES-1:0] word_q;
  logic [LANES-1:0] gathered;
  logic [LANES-1:0] mirrored;
  logic             ser_q;

  // Earliest bit ends up at the top of the gathered word.
  assign gathered = {shf_q[LANES-2:0], ser_in};

  for (genvar i = 0; i < LANES; i++) begin : g_mirror
    assign mirrored[i] = gathered[LANES-1-i];
  end

  assign load_o   = (pos_q == CNT_W'(LANES - 1));
  assign pos_nx_o = load_o ? '0 : pos_q + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      shf_q  <= '0;
      word_q <= '0;
      ser_q  <= 1'b0;
    end else begin
      pos_q <= pos_nx_o;
      shf_q <= gathered;
      ser_q <= ser_in;
      if (load_o) word_q <= rev ? mirrored : gathered;
    end
  end

  assign word_o    = word_q;
  assign ser_bit_o = ser_q;

endmodule

// File: rtl/rxfmt_clkgen.sv
module rxfmt_clkgen
  import rxfmt_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  clk_mode_e                mode,
  input  logic [1:0]               phase,
  input  logic [$clog2(LANES)-1:0] pos_nx,
  output logic                     clk_core_o
);
  logic        clk_q;
  logic        clk_d;
  logic        lvl;
  logic        hit;
  logic [31:0] dly;

  always_comb begin
    dly = phase_delay(phase, LANES);
    lvl = par_clk_level(32'(pos_nx), dly, LANES);
    hit = ddr_toggle(32'(pos_nx), dly, LANES);
    case (mode)
      CK_PAR_FULL: clk_d = lvl;
      CK_PAR_DDR:  clk_d = clk_q ^ hit;
      CK_SER_HALF: clk_d = ~clk_q;
      default:     clk_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_q <= 1'b0;
    else        clk_q <= clk_d;
  end

  assign clk_core_o = clk_q;

endmodule

// File: rtl/rxfmt_outgate.sv
module rxfmt_outgate
  import rxfmt_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  clk_mode_e        mode,
  input  logic             serial,
  input  logic             ser_bit,
  input  logic [LANES-1:0] word,
  input  logic             clk_core,
  input  logic             clk_off,
  input  logic             dat_off,
  output logic [LANES-1:0] dout,
  output logic             clk_out
);
  logic [LANES-1:0] lane_sel;
  logic             clk_src;

  assign lane_sel = serial ? {{(LANES-1){1'b0}}, ser_bit} : word;
  assign dout     = dat_off ? '0 : lane_sel;
  // Bit-rate serial clock passes the bit clock, held low in reset.
  assign clk_src  = (mode == CK_SER_FULL) ? (clk & rst_n) : clk_core;
  assign clk_out  = clk_off ? 1'b0 : clk_src;

endmodule

// File: rtl/rxfmt_top.sv
module rxfmt_top
  import rxfmt_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  input  logic             cfg_serial,
  input  logic             cfg_rev,
  input  logic             cfg_ddr,
  input  logic             cfg_ser_full,
  input  logic [1:0]       cfg_phase,
  input  logic             cfg_clk_off,
  input  logic             cfg_dat_off,
  output logic [LANES-1:0] dout,
  output logic             clk_out
);
  localparam int unsigned CNT_W = $clog2(LANES);

  // Named internal events, observed by the bound checker.
  logic [CNT_W-1:0] frame_pos_nx;
  logic             nib_load;
  logic [LANES-1:0] word;
  logic             ser_bit;
  logic             clk_core;
  clk_mode_e        clk_mode;

  assign clk_mode = pick_clk_mode(cfg_serial, cfg_ddr, cfg_ser_full);

  rxfmt_framer #(.LANES(LANES)) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_in    (ser_in),
    .rev       (cfg_rev),
    .pos_nx_o  (frame_pos_nx),
    .load_o    (nib_load),
    .word_o    (word),
    .ser_bit_o (ser_bit)
  );

  rxfmt_clkgen #(.LANES(LANES)) u_clkgen (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (clk_mode),
    .phase      (cfg_phase),
    .pos_nx     (frame_pos_nx),
    .clk_core_o (clk_core)
  );

  rxfmt_outgate #(.LANES(LANES)) u_outgate (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (clk_mode),
    .serial   (cfg_serial),
    .ser_bit  (ser_bit),
    .word     (word),
    .clk_core (clk_core),
    .clk_off  (cfg_clk_off),
    .dat_off  (cfg_dat_off),
    .dout     (dout),
    .clk_out  (clk_out)
  );

endmodule

// File: rtl/rxfmt_chk.sv
module rxfmt_chk
  import rxfmt_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ser_in,
  input logic             cfg_serial,
  input logic             cfg_clk_off,
  input logic             cfg_dat_off,
  input logic [LANES-1:0] dout_o,
  input logic             clk_o,
  input logic             nib_load,
  input clk_mode_e        clk_mode
);
  localparam int unsigned CW = $clog2(LANES);

  logic          past_ok;
  logic [CW-1:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
      cyc_q   <= '0;
    end else begin
      past_ok <= 1'b1;
      cyc_q   <= cyc_q + CW'(1);
    end
  end

  AST_DAT_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_dat_off |-> dout_o == '0);                                      // R11

  AST_CLK_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clk_off |-> !clk_o);                                            // R10

  AST_SERIAL_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && cfg_serial && $past(cfg_serial) && !cfg_dat_off)
      |-> dout_o == LANES'($past(ser_in)));                             // R4

  AST_SER_HALF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && clk_mode == CK_SER_HALF && $past(clk_mode) == CK_SER_HALF
     && !cfg_clk_off && !$past(cfg_clk_off))
      |-> clk_o != $past(clk_o));                                       // R8

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !cfg_serial && !$past(cfg_serial) && !$past(nib_load)
     && !cfg_dat_off && !$past(cfg_dat_off))
      |-> $stable(dout_o));                                             // R1

  AST_LOAD_CADENCE: assert property (@(posedge clk) disable iff (!rst_n)
    nib_load == (cyc_q == CW'(LANES - 1)));                             // R1

endmodule

bind rxfmt_top rxfmt_chk #(.LANES(LANES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ser_in      (ser_in),
  .cfg_serial  (cfg_serial),
  .cfg_clk_off (cfg_clk_off),
  .cfg_dat_off (cfg_dat_off),
  .dout_o      (dout),
  .clk_o       (clk_out),
  .nib_load    (nib_load),
  .clk_mode    (clk_mode)
);

// File: tb/rxfmt_top_tb.sv
`timescale 1ns/1ps
module rxfmt_top_tb;
  logic       clk;
  logic       rst_n;
  logic       ser_in;
  logic       cfg_serial, cfg_rev, cfg_ddr, cfg_ser_full;
  logic [1:0] cfg_phase;
  logic       cfg_clk_off, cfg_dat_off;
  logic [3:0] dout;
  logic       clk_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  rxfmt_top u_dut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in),
    .cfg_serial(cfg_serial), .cfg_rev(cfg_rev), .cfg_ddr(cfg_ddr),
    .cfg_ser_full(cfg_ser_full), .cfg_phase(cfg_phase),
    .cfg_clk_off(cfg_clk_off), .cfg_dat_off(cfg_dat_off),
    .dout(dout), .clk_out(clk_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {serial, rev, ddr, ser_full, phase[1:0], pattern[15:0] (MSB first), expected first output[3:0]}
  localparam int ROWS = 10;
  localparam logic [25:0] VECS [ROWS] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 16'hB4E1, 4'hB},
    {1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 16'hB4E1, 4'hD},
    {1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 16'h3C5A, 4'h3},
    {1'b0, 1'b1, 1'b0, 1'b0, 2'd2, 16'h3C5A, 4'hC},
    {1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 16'h96F0, 4'h9},
    {1'b0, 1'b1, 1'b1, 1'b0, 2'd3, 16'h96F0, 4'h9},
    {1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 16'h7001, 4'h7},
    {1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 16'hA5C3, 4'h1},
    {1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 16'h5A0F, 4'h0},
    {1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 16'h0FF0, 4'h0}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got=%0h exp=%0h", req, what, got, exp);
    end
  endtask

  function automatic int bench_delay(input logic [1:0] code);
    case (code)
      2'd0: return 0;
      2'd1: return 2;
      2'd2: return 1;
      default: return 3;
    endcase
  endfunction

  task automatic run_stream(input logic ser, input logic rev, input logic ddr,
                            input logic sfull, input logic [1:0] ph,
                            input logic [15:0] pat, input logic [3:0] first,
                            input logic [15:0] doff, input logic [15:0] coff);
    int d;
    int n;
    logic tog;
    logic [3:0] raw;
    logic [3:0] want;
    logic ck;
    string dreq;
    string creq;
    @(negedge clk);
    cfg_serial = ser; cfg_rev = rev; cfg_ddr = ddr; cfg_ser_full = sfull;
    cfg_phase = ph; cfg_clk_off = 1'b0; cfg_dat_off = 1'b0;
    rst_n = 1'b0; ser_in = 1'b1;
    @(posedge clk); #1;
    check("R12", "clk_out in reset (clock high)", 32'(clk_out), 0);
    check("R12", "dout in reset", 32'(dout), 0);
    @(negedge clk);
    rst_n = 1'b1;
    d = bench_delay(ph);
    tog = 1'b0;
    for (int k = 0; k < 16; k++) begin
      ser_in = pat[15-k];
      cfg_dat_off = doff[k];
      cfg_clk_off = coff[k];
      @(posedge clk); #1;
      if (ser && sfull && !coff[k])
        check("R9", "full-rate serial clock high phase", 32'(clk_out), 1);
      @(negedge clk);
      // data
      if (ser) begin
        want = {3'b000, pat[15-k]};
        dreq = "R4";
      end else if (k < 3) begin
        want = 4'h0;
        dreq = "R1";
      end else begin
        n = (k + 1) / 4 - 1;
        raw = pat[15-4*n -: 4];
        want = rev ? {raw[0], raw[1], raw[2], raw[3]} : raw;
        dreq = rev ? "R3" : "R2";
      end
      if (doff[k]) begin
        want = 4'h0;
        dreq = "R11";
      end else if (doff != 16'h0 && k > 0 && doff[k-1]) begin
        dreq = "R11";
      end
      check(dreq, $sformatf("dout after edge %0d", k), 32'(dout), 32'(want));
      if (!doff[k] && ((ser && k == 0) || (!ser && k == 3)))
        check(ser ? "R4" : "R1", "first output vs table", 32'(dout), 32'(first));
      // clock
      if (ser && sfull) begin
        ck = 1'b0;
        creq = "R9";
      end else if (ser) begin
        ck = ((k + 1) % 2) == 1;
        creq = "R8";
      end else if (ddr) begin
        if (((k + 1 + 4 - d) % 4) == 0) tog = ~tog;
        ck = tog;
        creq = "R7";
      end else begin
        ck = ((k + 1 + 4 - d) % 4) < 2;
        creq = (ph == 2'd0) ? "R5" : "R6";
      end
      if (coff[k]) begin
        ck = 1'b0;
        creq = "R10";
      end
      check(creq, $sformatf("clk_out after edge %0d", k), 32'(clk_out), 32'(ck));
    end
    cfg_dat_off = 1'b0;
    cfg_clk_off = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1; ser_in = 1'b0;
    cfg_serial = 1'b0; cfg_rev = 1'b0; cfg_ddr = 1'b0; cfg_ser_full = 1'b0;
    cfg_phase = 2'd0; cfg_clk_off = 1'b0; cfg_dat_off = 1'b0;
    #1 rst_n = 1'b0;
    // table walk
    for (int r = 0; r < ROWS; r++) begin
      run_stream(VECS[r][25], VECS[r][24], VECS[r][23], VECS[r][22],
                 VECS[r][21:20], VECS[r][19:4], VECS[r][3:0], 16'h0, 16'h0);
    end
    // R10: clock disabled for one word, data unaffected, clock phase resumes
    run_stream(1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 16'hC3A5, 4'hC, 16'h0, 16'h00F0);
    // R10: DDR clock disabled mid-stream, toggle history kept
    run_stream(1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 16'h5E17, 4'h5, 16'h0, 16'h0300);
    // R11: data disabled across a load, framing preserved afterwards
    run_stream(1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 16'h6D2B, 4'h6, 16'h00F0, 16'h0);
    // R10: bit-rate serial clock gated off
    run_stream(1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 16'hF00F, 4'h1, 16'h0, 16'h0F00);
    // R11: serial data disabled, lane 0 returns to live data
    run_stream(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 16'hE71B, 4'h1, 16'h0660, 16'h0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule